// File: doc/BRIEF.md
# Video Display Timing Generator

This block produces the raster timing for a video output path. A downstream frame fetch reads picture data using the pixel and line coordinates that the block presents. In master mode the block runs its own pixel and line counters from the video clock and derives horizontal and vertical sync from them. In slave mode it takes sync pulses from outside and pulls its counters into line with them. Either way it drives regenerated sync outputs, an active-video enable, a field bit and the coordinates.

The horizontal and vertical totals, active sizes, front porches and sync widths are programmable, together with the mode and the choice of progressive or interlaced scan. The horizontal registers are 12 bits wide and the vertical ones 11 bits wide, so active areas up to 1920x1080 fit. Every one of these settings is held in a shadow copy that changes only at a frame start. Each sync has its own polarity setting, which applies at once to both the generated output and the received input. In interlaced mode the vertical total gives the half-line count of a field. The line count is split between two fields, and the second field places its vertical sync edges at mid-line. In slave mode a missing sync is flagged.

Top module: `vidTimingGen`

## Requirements
- R1: While reset is asserted, pixelX, lineY, fieldId and syncLost are 0.
- R2: In master mode pixelX counts 0..H_total-1 and then wraps to 0. lineY advances at each wrap and returns to 0 after the last line of the field.
- R3: The unpolarised horizontal sync is active exactly while H_active+H_front <= pixelX < H_active+H_front+H_sync.
- R4: In progressive mode, and in field 0, the unpolarised vertical sync is active for whole lines with V_active+V_front <= lineY < V_active+V_front+V_sync.
- R5: activeVideo is 1 exactly when pixelX < H_active and lineY < V_active.
- R6: A polarity setting of 1 makes that sync active-high and 0 makes it active-low. This holds for the output and for the received input, and a change applies on the next cycle without waiting for a frame start.
- R7: In interlaced mode field 0 has ceil(V_total/2) lines and field 1 has floor(V_total/2) lines. fieldId toggles at every field end. In progressive mode fieldId stays 0.
- R8: In field 1 the vertical sync starts at pixelX = floor(H_total/2) of line V_active+V_front. It ends at the same pixel of line V_active+V_front+V_sync.
- R9: Changes to totals, sizes, porches, sync widths, mode and scan type take effect only at the next frame start. In master mode this is the wrap after the last line of progressive frames or of field 1. In slave mode it is a received vertical sync leading edge that leaves fieldId at 0.
- R10: In slave mode a received horizontal sync leading edge sets pixelX to H_active+H_front on the next cycle. A received vertical sync leading edge sets lineY to V_active+V_front on the next cycle. Counting then resumes.
- R11: In slave mode fieldId changes only at received vertical sync leading edges. It toggles at each such edge when interlaced and is 0 when progressive.
- R12: In slave mode syncLost rises once 2*H_total cycles pass with no horizontal leading edge, or 2*V_total line ends pass with no vertical leading edge. Each condition clears at its next leading edge. In master mode syncLost is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgHTotal | input | 12 | Pixels per line |
| cfgHActive | input | 12 | Active pixels per line |
| cfgHFront | input | 12 | Horizontal front porch |
| cfgHSync | input | 12 | Horizontal sync width |
| cfgVTotal | input | 11 | Lines per frame (progressive) or half-lines per field (interlaced) |
| cfgVActive | input | 11 | Active lines per frame or field |
| cfgVFront | input | 11 | Vertical front porch in lines |
| cfgVSync | input | 11 | Vertical sync width in lines |
| cfgSlave | input | 1 | 1 = follow received syncs, 0 = generate |
| cfgInterlace | input | 1 | 1 = interlaced, 0 = progressive |
| cfgHPol | input | 1 | Horizontal sync polarity, 1 = active-high |
| cfgVPol | input | 1 | Vertical sync polarity, 1 = active-high |
| hsyncIn | input | 1 | Received horizontal sync |
| vsyncIn | input | 1 | Received vertical sync |
| hsyncOut | output | 1 | Horizontal sync output |
| vsyncOut | output | 1 | Vertical sync output |
| activeVideo | output | 1 | Active-video enable |
| fieldId | output | 1 | Current field |
| pixelX | output | 12 | Current pixel coordinate |
| lineY | output | 11 | Current line coordinate within the field |
| syncLost | output | 1 | Received sync missing (slave mode) |

## Verification
The assertions rely on a consistent configuration. Both totals are at least 2, and each active size plus porch plus sync width fits inside its total. The vertical sync start also fits inside the shorter field. In slave mode they further rely on the horizontal settings not changing and on the received syncs already being synchronous to the video clock. The stimulus uses one small geometry of 20 pixels by 10 or 11 lines that meets all of these conditions. It changes only vertical settings while following external syncs, and it drives the received pulses from the same clock at the programmed period.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int HW = 12;
  localparam int VW = 11;

  typedef struct packed {
    logic [HW-1:0] hTot;
    logic [HW-1:0] hAct;
    logic [HW-1:0] hFp;
    logic [HW-1:0] hSw;
    logic [VW-1:0] vTot;
    logic [VW-1:0] vAct;
    logic [VW-1:0] vFp;
    logic [VW-1:0] vSw;
    logic          slave;
    logic          interlace;
  } vtgCfg_t;

  typedef struct packed {
    logic hAlign;
    logic vAlign;
  } vtgStrobe_t;

  typedef struct packed {
    logic lineEnd;
    logic fieldEnd;
  } vtgStatus_t;
endpackage

// File: rtl/vtg_datapath.sv
module vtg_datapath
  import vtg_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  vtgCfg_t       cfg,
  input  vtgStrobe_t    strobe,
  input  logic          field,
  output vtgStatus_t    status,
  output logic [HW-1:0] hCount,
  output logic [VW-1:0] vCount,
  output logic          hsAct,
  output logic          vsAct,
  output logic          active
);
  logic [HW-1:0] hSyncStart, hSyncEnd, hLast, hHalf;
  logic [VW-1:0] vSyncStart, vSyncEnd;
  logic [VW:0]   fieldLines, vLastWide;
  logic          vLastHit, halfLine, afterStart, beforeEnd;

  always_comb begin
    hSyncStart = cfg.hAct + cfg.hFp;
    hSyncEnd   = hSyncStart + cfg.hSw;
    hLast      = cfg.hTot - 1'b1;
    hHalf      = cfg.hTot >> 1;
    vSyncStart = cfg.vAct + cfg.vFp;
    vSyncEnd   = vSyncStart + cfg.vSw;
    if (!cfg.interlace)
      fieldLines = {1'b0, cfg.vTot};
    else if (field)
      fieldLines = {1'b0, cfg.vTot} >> 1;
    else
      fieldLines = ({1'b0, cfg.vTot} + 1'b1) >> 1;
    vLastWide = fieldLines - 1'b1;
    vLastHit  = ({1'b0, vCount} == vLastWide);
    status.lineEnd  = (hCount == hLast);
    status.fieldEnd = status.lineEnd && vLastHit;
  end

  // pixel and line counters; alignment strobes from the control side win
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCount <= '0;
      vCount <= '0;
    end else begin
      if (strobe.hAlign)      hCount <= hSyncStart;
      else if (status.lineEnd) hCount <= '0;
      else                     hCount <= hCount + 1'b1;

      if (strobe.vAlign)       vCount <= vSyncStart;
      else if (status.lineEnd) vCount <= vLastHit ? '0 : vCount + 1'b1;
    end
  end

  // sync windows; the second interlaced field shifts vertical edges by half a line
  always_comb begin
    halfLine   = cfg.interlace && field;
    hsAct      = (hCount >= hSyncStart) && (hCount < hSyncEnd);
    afterStart = (vCount > vSyncStart) ||
                 ((vCount == vSyncStart) && (!halfLine || (hCount >= hHalf)));
    beforeEnd  = (vCount < vSyncEnd) ||
                 ((vCount == vSyncEnd) && halfLine && (hCount < hHalf));
    vsAct      = afterStart && beforeEnd;
    active     = (hCount < cfg.hAct) && (vCount < cfg.vAct);
  end

  a_r2_pixel_step: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.hAlign |=> ((hCount == $past(hCount) + 1'b1) || (hCount == '0)));

  a_r2_pixel_bound: assert property (@(posedge clk) disable iff (!rstN)
    hCount < cfg.hTot);

  a_r2_line_bound: assert property (@(posedge clk) disable iff (!rstN)
    {1'b0, vCount} < fieldLines);
endmodule

// File: rtl/vtg_ctrl.sv
module vtg_ctrl
  import vtg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  vtgCfg_t    cfgIn,
  input  logic       hsyncIn,
  input  logic       vsyncIn,
  input  logic       hPol,
  input  logic       vPol,
  input  vtgStatus_t status,
  output vtgCfg_t    cfgEff,
  output vtgStrobe_t strobe,
  output logic       field,
  output logic       syncLost
);
  vtgCfg_t     shadow;
  logic        pending;
  logic        prevH, prevV, hInAct, vInAct, hEdge, vEdge;
  logic        flip, fieldNext, update;
  logic [HW:0] hGap;
  logic [VW:0] vGap;
  logic        hLost, vLost;

  always_comb begin
    cfgEff = pending ? cfgIn : shadow;
    hInAct = hPol ? hsyncIn : ~hsyncIn;
    vInAct = vPol ? vsyncIn : ~vsyncIn;
    hEdge  = cfgEff.slave & hInAct & ~prevH;
    vEdge  = cfgEff.slave & vInAct & ~prevV;
    strobe.hAlign = hEdge;
    strobe.vAlign = vEdge;
    flip      = cfgEff.slave ? vEdge : status.fieldEnd;
    fieldNext = cfgEff.interlace ? (field ^ flip) : 1'b0;
    if (pending)           update = 1'b1;
    else if (cfgEff.slave) update = vEdge & ~fieldNext;
    else                   update = status.fieldEnd & (~cfgEff.interlace | field);
    hLost    = cfgEff.slave & (hGap >= {cfgEff.hTot, 1'b0});
    vLost    = cfgEff.slave & (vGap >= {cfgEff.vTot, 1'b0});
    syncLost = hLost | vLost;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadow  <= '0;
      pending <= 1'b1;
      prevH   <= 1'b0;
      prevV   <= 1'b0;
      field   <= 1'b0;
    end else begin
      pending <= 1'b0;
      if (update) shadow <= cfgIn;
      prevH <= hInAct;
      prevV <= vInAct;
      field <= fieldNext;
    end
  end

  // saturating gap counters for received sync supervision
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hGap <= '0;
      vGap <= '0;
    end else begin
      if (!cfgEff.slave || hEdge) hGap <= '0;
      else if (hGap != '1)        hGap <= hGap + 1'b1;

      if (!cfgEff.slave || vEdge)                vGap <= '0;
      else if (status.lineEnd && (vGap != '1))   vGap <= vGap + 1'b1;
    end
  end

  a_r9_cfg_held: assert property (@(posedge clk) disable iff (!rstN)
    (!pending && !status.fieldEnd && !strobe.vAlign) |=> (cfgEff == $past(cfgEff)));

  a_r7_field_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEff.interlace && !status.fieldEnd && !strobe.vAlign) |=> (field == $past(field)));

  a_r7_prog_field0: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEff.interlace |=> !field);

  a_r12_edge_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hAlign |=> !hLost);
endmodule

// File: rtl/vidTimingGen.sv
module vidTimingGen
  import vtg_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic [HW-1:0] cfgHTotal,
  input  logic [HW-1:0] cfgHActive,
  input  logic [HW-1:0] cfgHFront,
  input  logic [HW-1:0] cfgHSync,
  input  logic [VW-1:0] cfgVTotal,
  input  logic [VW-1:0] cfgVActive,
  input  logic [VW-1:0] cfgVFront,
  input  logic [VW-1:0] cfgVSync,
  input  logic          cfgSlave,
  input  logic          cfgInterlace,
  input  logic          cfgHPol,
  input  logic          cfgVPol,
  input  logic          hsyncIn,
  input  logic          vsyncIn,
  output logic          hsyncOut,
  output logic          vsyncOut,
  output logic          activeVideo,
  output logic          fieldId,
  output logic [HW-1:0] pixelX,
  output logic [VW-1:0] lineY,
  output logic          syncLost
);
  vtgCfg_t    cfgIn, cfgEff;
  vtgStrobe_t strobe;
  vtgStatus_t status;
  logic       field, hsAct, vsAct;

  always_comb begin
    cfgIn.hTot      = cfgHTotal;
    cfgIn.hAct      = cfgHActive;
    cfgIn.hFp       = cfgHFront;
    cfgIn.hSw       = cfgHSync;
    cfgIn.vTot      = cfgVTotal;
    cfgIn.vAct      = cfgVActive;
    cfgIn.vFp       = cfgVFront;
    cfgIn.vSw       = cfgVSync;
    cfgIn.slave     = cfgSlave;
    cfgIn.interlace = cfgInterlace;
  end

  vtg_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cfgIn(cfgIn),
    .hsyncIn(hsyncIn), .vsyncIn(vsyncIn), .hPol(cfgHPol), .vPol(cfgVPol),
    .status(status), .cfgEff(cfgEff), .strobe(strobe),
    .field(field), .syncLost(syncLost)
  );

  vtg_datapath dp_i (
    .clk(clk), .rstN(rstN), .cfg(cfgEff), .strobe(strobe), .field(field),
    .status(status), .hCount(pixelX), .vCount(lineY),
    .hsAct(hsAct), .vsAct(vsAct), .active(activeVideo)
  );

  assign hsyncOut = cfgHPol ? hsAct : ~hsAct;
  assign vsyncOut = cfgVPol ? vsAct : ~vsAct;
  assign fieldId  = field;
endmodule

// File: tb/vidTimingGen_tb_top.sv
module vidTimingGen_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN;
  logic [11:0] cfgHTotal, cfgHActive, cfgHFront, cfgHSync;
  logic [10:0] cfgVTotal, cfgVActive, cfgVFront, cfgVSync;
  logic cfgSlave, cfgInterlace, cfgHPol, cfgVPol, hsyncIn, vsyncIn;
  logic hsyncOut, vsyncOut, activeVideo, fieldId, syncLost;
  logic [11:0] pixelX;
  logic [10:0] lineY;

  vidTimingGen dut_i (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  int mx, my, mf, mHT, mHA, mHF, mHS, mVT, mVA, mVF, mVS, mIl;
  int ex, ey;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic loadModel();
    mHT = cfgHTotal; mHA = cfgHActive; mHF = cfgHFront; mHS = cfgHSync;
    mVT = cfgVTotal; mVA = cfgVActive; mVF = cfgVFront; mVS = cfgVSync;
    mIl = cfgInterlace;
  endtask

  task automatic advModel();
    int fl;
    bit frameEnd;
    fl = (mIl == 0) ? mVT : ((mf != 0) ? mVT / 2 : (mVT + 1) / 2);
    if (mx == mHT - 1) begin
      mx = 0;
      if (my == fl - 1) begin
        my = 0;
        frameEnd = (mIl == 0) || (mf != 0);
        if (mIl != 0) mf = 1 - mf;
        if (frameEnd) loadModel();
      end else my++;
    end else mx++;
  endtask

  task automatic checkModel();
    int hss, vss, pos;
    bit hs, vs, act;
    hss = mHA + mHF;
    vss = mVA + mVF;
    hs  = (mx >= hss) && (mx < hss + mHS);
    if (mIl != 0 && mf != 0) begin
      pos = my * mHT + mx;
      vs  = (pos >= vss * mHT + mHT / 2) && (pos < (vss + mVS) * mHT + mHT / 2);
    end else
      vs = (my >= vss) && (my < vss + mVS);
    act = (mx < mHA) && (my < mVA);
    chk("R2/R9 pixelX", pixelX, mx);
    chk("R2 lineY", lineY, my);
    chk("R3/R6 hsyncOut", hsyncOut, cfgHPol ? hs : !hs);
    chk("R4/R8 vsyncOut", vsyncOut, cfgVPol ? vs : !vs);
    chk("R5 activeVideo", activeVideo, act);
    chk("R7 fieldId", fieldId, mf);
    chk("R12 syncLost master", syncLost, 0);
  endtask

  task automatic runModel(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      advModel();
      @(negedge clk);
      checkModel();
    end
  endtask

  // one cycle of externally generated syncs, active-low, 20 pixels by 10 lines
  task automatic extStep(input bit doH, input bit doV);
    hsyncIn = doH ? !(ex < 3) : 1'b1;
    vsyncIn = doV ? !(ey == 0) : 1'b1;
    @(posedge clk);
    ex++;
    if (ex == 20) begin
      ex = 0;
      ey = (ey + 1) % 10;
    end
    @(negedge clk);
  endtask

  task automatic toVsyncEdge();
    do extStep(1, 1); while (!(ey == 0 && ex == 1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    cfgHTotal = 20; cfgHActive = 12; cfgHFront = 2; cfgHSync = 3;
    cfgVTotal = 10; cfgVActive = 6;  cfgVFront = 1; cfgVSync = 2;
    cfgSlave = 0; cfgInterlace = 0; cfgHPol = 1; cfgVPol = 1;
    hsyncIn = 1'b1; vsyncIn = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pixelX", pixelX, 0);
    chk("R1 lineY", lineY, 0);
    chk("R1 fieldId", fieldId, 0);
    chk("R1 syncLost", syncLost, 0);
    loadModel();
    mx = 0; my = 0; mf = 0;
    rstN = 1'b1;

    // master progressive, active-high syncs
    runModel(450);
    // R6 polarity flip, immediate
    cfgHPol = 0; cfgVPol = 0;
    runModel(100);
    // R9 shorter line programmed mid-frame
    cfgHTotal = 18;
    runModel(500);
    // R7/R8 interlaced, 11 half-lines per field
    cfgHTotal = 20; cfgInterlace = 1;
    cfgVTotal = 11; cfgVActive = 2; cfgVFront = 1; cfgVSync = 1;
    runModel(700);
    // back to progressive, then hand over to slave at a frame start
    cfgInterlace = 0;
    cfgVTotal = 10; cfgVActive = 6; cfgVFront = 1; cfgVSync = 2;
    do runModel(1);
    while (!(mx == 0 && my == 0 && mf == 0 && mIl == 0 && mVT == 10 && mHT == 20));
    cfgSlave = 1;
    runModel(200);

    // slave mode, active-low received syncs (R6)
    ex = 0; ey = 0;
    extStep(1, 1);
    chk("R10 pixelX after hsync edge", pixelX, 14);
    chk("R10 lineY after vsync edge", lineY, 7);
    chk("R11 fieldId progressive slave", fieldId, 0);
    repeat (6) extStep(1, 1);
    chk("R10 pixelX resumes and wraps", pixelX, 0);
    chk("R10 lineY advances", lineY, 8);
    repeat (400) extStep(1, 1);
    chk("R12 no loss with steady syncs", syncLost, 0);

    // R12 horizontal loss threshold
    do extStep(1, 1); while (ex != 1);
    repeat (39) extStep(0, 1);
    chk("R12 below horizontal threshold", syncLost, 0);
    extStep(0, 1);
    chk("R12 horizontal loss", syncLost, 1);
    do extStep(1, 1); while (ex != 1);
    chk("R12 horizontal loss cleared", syncLost, 0);

    // R12 vertical loss threshold
    toVsyncEdge();
    repeat (300) extStep(1, 0);
    chk("R12 below vertical threshold", syncLost, 0);
    repeat (120) extStep(1, 0);
    chk("R12 vertical loss", syncLost, 1);
    toVsyncEdge();
    chk("R12 vertical loss cleared", syncLost, 0);

    // R9/R11 slave interlace takes effect at the next vsync edge
    cfgInterlace = 1; cfgVTotal = 20;
    toVsyncEdge();
    chk("R9 update edge keeps field 0", fieldId, 0);
    chk("R10 lineY on vsync edge", lineY, 7);
    toVsyncEdge();
    chk("R11 field toggles to 1", fieldId, 1);
    toVsyncEdge();
    chk("R11 field toggles to 0", fieldId, 0);
    repeat (30) extStep(1, 1);
    chk("R11 field held between edges", fieldId, 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule